// File: doc/BRIEF.md
# Quadlet Stream CRC-16 Engine

This block computes the 16-bit check value that protects self-describing data blocks on a serial bus node, such as a topology-style map or a speed-style map. A producer first pulses `start_i` with the number of 32-bit quadlets the block holds. It then hands the quadlets over one at a time with a valid/ready handshake. Inside, each quadlet is folded into the checksum one 4-bit nibble per clock, beginning with the most significant nibble.

Once the last nibble of the last quadlet has been folded, `done_o` pulses for one cycle. At that point `crc_o` holds the final check value, and `header_o` holds the header quadlet that precedes the block in memory: the covered length in the upper half and the checksum in the lower half. The caller picks the length. For a topology-style map it is the self-ID count plus two. For a speed-style map it is always 1009 quadlets. A fresh `start_i` may arrive at any time. It drops whatever block is in progress and begins again from zero.

Top module: `qcrc_engine`

## Requirements
- R1: After reset, `busy_o`, `qd_ready_o` and `done_o` are 0 and `crc_o` is 0.
- R2: A cycle with `start_i` high clears `crc_o` to 0 on the following edge and records `count_i` as the block length. With a nonzero count, `qd_ready_o` is high in the next cycle.
- R3: Each nibble is folded with s = (c[15:12] XOR n) and c' = ((c << 4) XOR (s << 12) XOR (s << 5) XOR s) mod 2^16. The nibbles of a quadlet are taken in the order bits 31:28, 27:24, ... down to bits 3:0.
- R4: `qd_ready_o` is low from the cycle after an accepted quadlet until all eight of its nibbles are folded. It is never high while `busy_o` is low. With `qd_valid_i` held high, consecutive quadlets are accepted exactly 8 cycles apart.
- R5: `done_o` is high for exactly one cycle, 7 cycles after the edge that accepted the last quadlet. From then until the next start, `crc_o` holds the check value of all N quadlets and does not change.
- R6: A start with a count of 0 raises `done_o` in the next cycle with `crc_o` = 0 and `busy_o` = 0.
- R7: A start that arrives while a block is in progress discards that block. The new block's result equals the result of the same block run from idle.
- R8: `header_o` = {length as 16 bits, `crc_o`}, where the length is the count captured at the last start.
- R9: Idle cycles with `qd_valid_i` low between quadlets do not change the result.
- R10: While `start_i` is high, `qd_ready_o` is low, so a quadlet offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new block, aborting any block in progress |
| count_i | input | CNT_W | Number of quadlets in the block, sampled with start_i |
| qd_valid_i | input | 1 | Quadlet offered |
| qd_data_i | input | DATA_W | Quadlet value |
| qd_ready_o | output | 1 | Engine can take a quadlet this cycle |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle pulse when the check value is final |
| crc_o | output | 16 | Running and final check value |
| header_o | output | 32 | Length in bits 31:16, check value in bits 15:0 |

## Verification
The hardest case to reach is an abort that lands in the middle of a quadlet, while the nibble sequencer is partway through its eight steps and the checksum register holds a partial value. The bench gets there by waiting a fixed number of cycles after an accept and then issuing a new start. It also offers a decoy quadlet in the same cycle as a start, to show that the decoy never enters the checksum. Near-exhaustive sweeps put every nibble value in every nibble position of a single quadlet. Random-length blocks, with and without idle gaps, and a full 1009-quadlet block cover the length counter.

// File: rtl/qcrc_pkg.sv
`timescale 1ns/1ps
package qcrc_pkg;
   localparam int CRC_W = 16;
   localparam int NIB_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } qcrc_state_e;
endpackage

// File: rtl/qcrc_step.sv
`timescale 1ns/1ps
module qcrc_step
   import qcrc_pkg::*;
(
   input  logic [CRC_W-1:0] crc_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [NIB_W-1:0] fb;

   always_comb begin
      fb    = crc_i[CRC_W-1 -: NIB_W] ^ nib_i;
      crc_o = {crc_i[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}}
            ^ {fb, 12'h000}
            ^ {7'b0, fb, 5'b0}
            ^ {12'h000, fb};
   end
endmodule

// File: rtl/qcrc_fold.sv
`timescale 1ns/1ps
module qcrc_fold
   import qcrc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STEPS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   localparam int SHIFT = STEPS * NIB_W;

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] src;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  chain [STEPS+1];

   assign src      = load_i ? data_i : sh_q;
   assign chain[0] = crc_q;

   for (genvar k = 0; k < STEPS; k++) begin : g_step
      qcrc_step u_step (
         .crc_i (chain[k]),
         .nib_i (src[DATA_W-1-k*NIB_W -: NIB_W]),
         .crc_o (chain[k+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
         sh_q  <= '0;
      end else if (clear_i) begin
         crc_q <= '0;
         sh_q  <= '0;
      end else if (load_i || adv_i) begin
         crc_q <= chain[STEPS];
         sh_q  <= src << SHIFT;
      end
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/qcrc_ctrl.sv
`timescale 1ns/1ps
module qcrc_ctrl
   import qcrc_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int BEATS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             qd_valid_i,
   output logic             qd_ready_o,
   output logic             clear_o,
   output logic             load_o,
   output logic             adv_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] len_o
);
   localparam int BEAT_W = (BEATS < 2) ? 1 : $clog2(BEATS + 1);

   qcrc_state_e      st_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] len_q;
   logic [BEAT_W-1:0] beat_q;
   logic             done_q;
   logic             last_beat;

   assign qd_ready_o = !start_i && (st_q == ST_WAIT);
   assign load_o     = qd_ready_o && qd_valid_i;
   assign adv_o      = !start_i && (st_q == ST_RUN);
   assign clear_o    = start_i;

   if (BEATS == 1) begin : g_single
      assign last_beat = load_o;
   end else begin : g_multi
      assign last_beat = adv_o && (beat_q == BEAT_W'(BEATS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         len_q  <= '0;
         beat_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            len_q  <= count_i;
            rem_q  <= count_i;
            beat_q <= '0;
            if (count_i == '0) begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end else begin
               st_q <= ST_WAIT;
            end
         end else begin
            if (load_o) begin
               beat_q <= BEAT_W'(1);
               if (BEATS > 1) st_q <= ST_RUN;
            end
            if (adv_o) beat_q <= beat_q + 1'b1;
            if (last_beat) begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == CNT_W'(1)) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  st_q <= ST_WAIT;
               end
            end
         end
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = done_q;
   assign len_o  = len_q;
endmodule

// File: rtl/qcrc_engine.sv
`timescale 1ns/1ps
module qcrc_engine
   import qcrc_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 12,
   parameter int STEPS_PER_CLK = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic                qd_valid_i,
   input  logic [DATA_W-1:0]   qd_data_i,
   output logic                qd_ready_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [CRC_W-1:0]    crc_o,
   output logic [2*CRC_W-1:0]  header_o
);
   localparam int NIBS  = DATA_W / NIB_W;
   localparam int BEATS = NIBS / STEPS_PER_CLK;
   localparam int LEN_W = CRC_W;

   initial begin : param_check
      if (DATA_W % NIB_W != 0)
         $error("qcrc_engine: DATA_W must be a multiple of the nibble width");
      if (STEPS_PER_CLK < 1 || NIBS % STEPS_PER_CLK != 0)
         $error("qcrc_engine: STEPS_PER_CLK must divide the nibbles per quadlet");
      if (CNT_W < 1 || CNT_W > LEN_W)
         $error("qcrc_engine: CNT_W must fit the header length field");
   end

   logic             clear;
   logic             load;
   logic             adv;
   logic [CNT_W-1:0] len;

   qcrc_ctrl #(.CNT_W(CNT_W), .BEATS(BEATS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .count_i    (count_i),
      .qd_valid_i (qd_valid_i),
      .qd_ready_o (qd_ready_o),
      .clear_o    (clear),
      .load_o     (load),
      .adv_o      (adv),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .len_o      (len)
   );

   qcrc_fold #(.DATA_W(DATA_W), .STEPS(STEPS_PER_CLK)) u_fold (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .load_i  (load),
      .adv_i   (adv),
      .data_i  (qd_data_i),
      .crc_o   (crc_o)
   );

   assign header_o = {LEN_W'(len), crc_o};
endmodule

// File: rtl/qcrc_engine_chk.sv
`timescale 1ns/1ps
module qcrc_engine_chk #(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 12,
   parameter int STEPS_PER_CLK = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] count_i,
   input logic             qd_valid_i,
   input logic             qd_ready_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [15:0]      crc_o,
   input logic [31:0]      header_o
);
   localparam int BEATS = (DATA_W / 4) / STEPS_PER_CLK;

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (crc_o == 16'h0000));

   assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((BEATS > 1) && qd_valid_i && qd_ready_o) |=> !qd_ready_o);

   assert_idle_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !qd_ready_o);

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(crc_o));

   assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && count_i == '0) |=> (done_o && crc_o == 16'h0000 && !busy_o));

   assert_header_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (header_o[31:16] == 16'($past(count_i))));

   assert_no_take_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !qd_ready_o);
endmodule

bind qcrc_engine qcrc_engine_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .STEPS_PER_CLK(STEPS_PER_CLK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .count_i    (count_i),
   .qd_valid_i (qd_valid_i),
   .qd_ready_o (qd_ready_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .crc_o      (crc_o),
   .header_o   (header_o)
);

// File: tb/qcrc_engine_test.sv
`timescale 1ns/1ps
module qcrc_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] count_i = '0;
   logic        qd_valid_i = 1'b0;
   logic [31:0] qd_data_i = '0;
   logic        qd_ready_o, busy_o, done_o;
   logic [15:0] crc_o;
   logic [31:0] header_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [31:0] blk [1024];
   logic [31:0] seed = 32'h1234_5677;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   qcrc_engine uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
      .qd_valid_i(qd_valid_i), .qd_data_i(qd_data_i), .qd_ready_o(qd_ready_o),
      .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o), .header_o(header_o)
   );

   function automatic logic [31:0] next_rand(logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   function automatic logic [15:0] ref_crc(int n);
      logic [15:0] c = 16'h0;
      for (int q = 0; q < n; q++) begin
         for (int p = 7; p >= 0; p--) begin
            logic [3:0] s;
            s = c[15:12] ^ blk[q][p*4 +: 4];
            c = (c << 4) ^ ({12'h0, s} << 12) ^ ({12'h0, s} << 5) ^ {12'h0, s};
         end
      end
      return c;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(int n);
      for (int i = 0; i < n; i++) begin
         seed = next_rand(seed);
         blk[i] = seed;
      end
   endtask

   // feed n quadlets after start has been issued, then check the result
   task automatic feed_and_finish(int n, bit gaps);
      int prev_acc = -1;
      int w;
      for (int q = 0; q < n; q++) begin
         if (gaps && blk[q][0]) begin
            qd_valid_i = 1'b0;
            repeat (int'(blk[q][3:1]) + 1) @(negedge clk);
         end
         qd_valid_i = 1'b1;
         qd_data_i  = blk[q];
         #1;
         while (!qd_ready_o) begin
            @(negedge clk);
            #1;
         end
         if (!gaps && prev_acc >= 0)
            check(cyc - prev_acc == 8, "R4 accept spacing", cyc - prev_acc, 8);
         prev_acc = cyc;
         @(negedge clk);
         qd_valid_i = 1'b0;
         qd_data_i  = 32'hDEAD_BEEF;
         #1;
         if (q == 0) check(!qd_ready_o, "R4 ready low while folding", qd_ready_o, 0);
      end
      w = 0;
      while (!done_o && w < 40) begin
         @(negedge clk);
         #1;
         w++;
      end
      check(w == 7, "R5 done latency", w, 7);
      check(crc_o == ref_crc(n), gaps ? "R9 crc with gaps" : "R3 crc value", crc_o, ref_crc(n));
      check(header_o == {16'(n), ref_crc(n)}, "R8 header", header_o, {16'(n), ref_crc(n)});
      @(negedge clk);
      #1;
      check(!done_o && crc_o == ref_crc(n), "R5 pulse and hold", {done_o, 15'h0, crc_o}, {16'h0, ref_crc(n)});
   endtask

   task automatic run_block(int n, bit gaps);
      @(negedge clk);
      start_i = 1'b1;
      count_i = 12'(n);
      @(negedge clk);
      start_i = 1'b0;
      #1;
      check(crc_o == 16'h0 && qd_ready_o == (n != 0), "R2 start clears", {qd_ready_o, 15'h0, crc_o}, {15'h0, n != 0, 16'h0});
      if (n == 0) begin
         check(done_o && !busy_o && crc_o == 0, "R6 zero count", {done_o, busy_o, crc_o}, 32'h20000);
      end else begin
         feed_and_finish(n, gaps);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      check(!busy_o && !qd_ready_o && !done_o && crc_o == 0, "R1 reset state",
            {busy_o, qd_ready_o, done_o, crc_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!busy_o && !qd_ready_o && !done_o && crc_o == 0, "R1 after release",
            {busy_o, qd_ready_o, done_o, crc_o}, 0);

      // R3: every nibble value in every nibble position of a single quadlet
      for (int pos = 0; pos < 8; pos++) begin
         for (int v = 0; v < 16; v++) begin
            blk[0] = 32'(v) << (4 * pos);
            run_block(1, 1'b0);
         end
      end

      // R5 / R9: random blocks of varying length, with and without gaps
      for (int len = 1; len <= 24; len++) begin
         fill(len);
         run_block(len, len[0]);
      end

      // R6: zero-length blocks, including one straight after another
      run_block(0, 1'b0);
      run_block(0, 1'b0);

      // R7: abort in the middle of a quadlet
      fill(6);
      @(negedge clk);
      start_i = 1'b1;
      count_i = 12'd6;
      @(negedge clk);
      start_i = 1'b0;
      qd_valid_i = 1'b1;
      qd_data_i = blk[0];
      #1;
      while (!qd_ready_o) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      qd_valid_i = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(busy_o, "R7 mid-block busy", busy_o, 1);
      fill(4);
      run_block(4, 1'b0);

      // R10: decoy quadlet offered together with start is not taken
      fill(2);
      @(negedge clk);
      start_i = 1'b1;
      count_i = 12'd2;
      @(negedge clk);
      start_i = 1'b0;
      #1;
      @(negedge clk);
      start_i = 1'b1;
      count_i = 12'd1;
      qd_valid_i = 1'b1;
      qd_data_i = 32'hA5A5_0F0F;
      #1;
      check(!qd_ready_o, "R10 ready low during start", qd_ready_o, 0);
      @(negedge clk);
      start_i = 1'b0;
      qd_valid_i = 1'b0;
      feed_and_finish(1, 1'b0);

      // topology-style map: self-ID count 5 plus 2
      fill(7);
      run_block(7, 1'b0);

      // speed-style map: fixed 1009 quadlets
      fill(1009);
      run_block(1009, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule